// File: doc/BRIEF.md
# BISYNC receive character filter

This stage sits directly after receive character framing in a byte-synchronous receiver. It takes one received character per input strobe, together with its parity bit, and removes sync fill from the stream before the character reaches buffering. The removal rule depends on the framing mode. In normal (non-transparent) mode, every character equal to the programmed sync value is discarded. In transparent mode, only an escape character immediately followed by a sync character is discarded, so sync-valued payload bytes reach the output.

Each character that survives is presented on a registered output strobe with two flags. The first is a parity error flag. The second is a control-character match flag, taken from a bank of eight programmable comparators, each with its own enable; it carries the index of the lowest-numbered comparator that matches. A saturating counter records parity errors on kept characters and is zeroed by a clear strobe.

Top module: `sync_rx_filter`

## Requirements
- R1: With `transp_i` low, a strobed character equal to `sync_char_i` produces no output strobe. Any other character appears on `out_data_o` with `out_vld_o` high in the cycle after the clock edge that sampled it.
- R2: With `transp_i` high, a character that is not `dle_char_i` and does not follow a pending escape is output in the cycle after it is sampled. This includes a character equal to `sync_char_i`.
- R3: With `transp_i` high, an escape character produces no output when it is sampled and becomes pending. If the next character is the sync value, neither character is output. If the next character is any other non-escape value, the escape character is output in the cycle after that next character is sampled, and the next character is output in the cycle after that.
- R4: With `transp_i` high, a pending escape followed by a second escape character yields one escape data byte and clears the pending state. Its error flag is the OR of the two characters' parity errors.
- R5: A character has a parity error when `par_en_i` is high and the XOR of its eight data bits and `in_par_i` differs from `par_odd_i`; 1 selects odd parity and 0 selects even. With `par_en_i` low, no character is flagged.
- R6: `out_ctrl_hit_o` is high with an output strobe when some register i, with `ctrl_en_i[i]` set and value `ctrl_char_i[8*i+7:8*i]`, equals the output byte. `out_ctrl_idx_o` then gives the lowest such i. Both flags stay low when no strobe is present.
- R7: `par_err_cnt_o` rises by one in the cycle after each output strobe whose `out_par_err_o` is high, and holds at all ones once it gets there.
- R8: A high `cnt_clr_i` makes the counter zero on the next cycle, even when an increment is due on the same edge.
- R9: Discarded characters never produce an output strobe and never change the counter, whatever their parity.
- R10: Out of reset, `out_vld_o`, `out_ctrl_hit_o` and `par_err_cnt_o` are zero, and no escape is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| transp_i | input | 1 | 1 = transparent mode, 0 = normal mode |
| sync_char_i | input | 8 | Sync character value |
| dle_char_i | input | 8 | Escape (DLE) character value |
| par_en_i | input | 1 | Parity check enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| ctrl_char_i | input | 64 | Eight control character values, register i in bits [8i+7:8i] |
| ctrl_en_i | input | 8 | Per-register match enable |
| in_vld_i | input | 1 | Received character strobe |
| in_data_i | input | 8 | Received character |
| in_par_i | input | 1 | Received parity bit |
| cnt_clr_i | input | 1 | Parity error counter clear |
| out_vld_o | output | 1 | Kept character strobe |
| out_data_o | output | 8 | Kept character |
| out_par_err_o | output | 1 | Parity error on kept character |
| out_ctrl_hit_o | output | 1 | Control character match |
| out_ctrl_idx_o | output | 3 | Lowest matching register index |
| par_err_cnt_o | output | 16 | Saturating parity error count |

## Verification
The assertions assume that character strobes are never on two consecutive cycles. A serial character takes many bit times, so this holds on the real input, and it leaves a free slot for the held-back character of R3. They also assume that the mode, the sync and escape values and the control registers change only while no character is in flight. The stimulus spaces every strobe two cycles apart, changes the configuration only between phases after idle cycles, and switches modes only with no escape pending.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
  typedef struct packed {
    char_t data;
    logic  err;
  } rx_chr_t;
endpackage

// File: rtl/srf_parity.sv
module srf_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         par_i,
  input  logic         en_i,
  input  logic         odd_i,
  output logic         err_o
);
  assign err_o = en_i & ((^{data_i, par_i}) != odd_i);
endmodule

// File: rtl/srf_ctrl_match.sv
module srf_ctrl_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W-1:0]   data_i,
  input  logic [N*W-1:0] chars_i,
  input  logic [N-1:0]   en_i,
  output logic           hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = en_i[g] && (chars_i[g*W +: W] == data_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/srf_err_cnt.sv
module srf_err_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sync_rx_filter.sv
module sync_rx_filter
  import srf_pkg::*;
#(
  parameter int unsigned N_CTRL = 8,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     transp_i,
  input  logic [CHAR_W-1:0]        sync_char_i,
  input  logic [CHAR_W-1:0]        dle_char_i,
  input  logic                     par_en_i,
  input  logic                     par_odd_i,
  input  logic [N_CTRL*CHAR_W-1:0] ctrl_char_i,
  input  logic [N_CTRL-1:0]        ctrl_en_i,
  input  logic                     in_vld_i,
  input  logic [CHAR_W-1:0]        in_data_i,
  input  logic                     in_par_i,
  input  logic                     cnt_clr_i,
  output logic                     out_vld_o,
  output logic [CHAR_W-1:0]        out_data_o,
  output logic                     out_par_err_o,
  output logic                     out_ctrl_hit_o,
  output logic [IDX_W-1:0]         out_ctrl_idx_o,
  output logic [CNT_W-1:0]         par_err_cnt_o
);
  logic    in_err;
  logic    is_sync, is_dle;
  logic    esc_q, esc_n, esc_err_q, esc_err_n;
  logic    rel_q, rel_n;
  rx_chr_t rel_c_q, rel_c_n;
  logic    emit_n, out_vld_q;
  rx_chr_t emit_c, out_c_q;
  logic    hit;

  srf_parity #(.W(CHAR_W)) u_par (
    .data_i (in_data_i),
    .par_i  (in_par_i),
    .en_i   (par_en_i),
    .odd_i  (par_odd_i),
    .err_o  (in_err)
  );

  assign is_sync = (in_data_i == sync_char_i);
  assign is_dle  = (in_data_i == dle_char_i);

  always_comb begin
    emit_n    = 1'b0;
    emit_c    = '0;
    esc_n     = esc_q;
    esc_err_n = esc_err_q;
    rel_n     = rel_q;
    rel_c_n   = rel_c_q;
    if (in_vld_i) begin
      if (!transp_i) begin
        esc_n = 1'b0;
        if (!is_sync) begin
          emit_n = 1'b1;
          emit_c = '{data: in_data_i, err: in_err};
        end
      end else if (!esc_q) begin
        if (is_dle) begin
          esc_n     = 1'b1;
          esc_err_n = in_err;
        end else begin
          emit_n = 1'b1;
          emit_c = '{data: in_data_i, err: in_err};
        end
      end else begin
        esc_n = 1'b0;
        if (is_dle) begin
          emit_n = 1'b1;
          emit_c = '{data: dle_char_i, err: esc_err_q | in_err};
        end else if (!is_sync) begin
          // escape first, the following character one slot later
          emit_n  = 1'b1;
          emit_c  = '{data: dle_char_i, err: esc_err_q};
          rel_n   = 1'b1;
          rel_c_n = '{data: in_data_i, err: in_err};
        end
      end
    end else if (rel_q) begin
      emit_n = 1'b1;
      emit_c = rel_c_q;
      rel_n  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esc_q     <= 1'b0;
      esc_err_q <= 1'b0;
      rel_q     <= 1'b0;
      rel_c_q   <= '0;
      out_vld_q <= 1'b0;
      out_c_q   <= '0;
    end else begin
      esc_q     <= esc_n;
      esc_err_q <= esc_err_n;
      rel_q     <= rel_n;
      rel_c_q   <= rel_c_n;
      out_vld_q <= emit_n;
      if (emit_n) out_c_q <= emit_c;
    end
  end

  srf_ctrl_match #(.N(N_CTRL), .W(CHAR_W)) u_match (
    .data_i  (out_c_q.data),
    .chars_i (ctrl_char_i),
    .en_i    (ctrl_en_i),
    .hit_o   (hit),
    .idx_o   (out_ctrl_idx_o)
  );

  srf_err_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (out_vld_q & out_c_q.err),
    .cnt_o  (par_err_cnt_o)
  );

  assign out_vld_o      = out_vld_q;
  assign out_data_o     = out_c_q.data;
  assign out_par_err_o  = out_vld_q & out_c_q.err;
  assign out_ctrl_hit_o = out_vld_q & hit;
endmodule

// File: rtl/srf_chk.sv
module srf_chk
  import srf_pkg::*;
#(
  parameter int unsigned N_CTRL = 8,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     transp_i,
  input logic [CHAR_W-1:0]        sync_char_i,
  input logic [N_CTRL*CHAR_W-1:0] ctrl_char_i,
  input logic [N_CTRL-1:0]        ctrl_en_i,
  input logic                     in_vld_i,
  input logic                     cnt_clr_i,
  input logic                     out_vld_o,
  input logic [CHAR_W-1:0]        out_data_o,
  input logic                     out_par_err_o,
  input logic                     out_ctrl_hit_o,
  input logic [IDX_W-1:0]         out_ctrl_idx_o,
  input logic [CNT_W-1:0]         par_err_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // input assumption that frees the release slot (R3)
  p_in_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i |=> !in_vld_i);

  p_no_sync_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && !transp_i) |-> (out_data_o != sync_char_i));

  p_out_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> ($past(in_vld_i) || $past(in_vld_i, 2)));

  p_hit_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ctrl_hit_o |-> (ctrl_en_i[out_ctrl_idx_o] &&
      ctrl_char_i[int'(out_ctrl_idx_o)*CHAR_W +: CHAR_W] == out_data_o));

  p_flags_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> (!out_ctrl_hit_o && !out_par_err_o));

  p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && par_err_cnt_o == CMAX) |=> (par_err_cnt_o == CMAX));

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !out_par_err_o) |=> $stable(par_err_cnt_o));

  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (par_err_cnt_o == '0));
endmodule

bind sync_rx_filter srf_chk #(.N_CTRL(N_CTRL), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_sync_rx_filter.sv
module sim_sync_rx_filter;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NC     = 8;
  localparam int unsigned CW     = 8;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [7:0] SYNC = 8'h32;
  localparam logic [7:0] DLE  = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic transp = 1'b0, par_en = 1'b1, par_odd = 1'b1;
  logic [NC*8-1:0] ctrl_chars;
  logic [NC-1:0] ctrl_en = 8'b0111_1111;
  logic in_vld = 1'b0, in_par = 1'b0, cnt_clr = 1'b0;
  logic [7:0] in_data = '0;
  logic out_vld, out_err, out_hit;
  logic [7:0] out_data;
  logic [2:0] out_idx;
  logic [CW-1:0] cnt;

  logic [7:0] creg [NC] = '{8'h03, 8'h10, 8'h2D, 8'h41, 8'h7F, 8'h2D, 8'hC5, 8'hFE};

  int n_chk = 0, n_fail = 0;
  logic [7:0] q_d [$];
  bit q_e [$];
  string q_t [$];
  bit m_esc = 0, m_esc_err = 0;
  logic [CW-1:0] cnt_exp = '0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_cr
    assign ctrl_chars[g*8 +: 8] = creg[g];
  end

  sync_rx_filter #(.N_CTRL(NC), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .transp_i(transp),
    .sync_char_i(SYNC), .dle_char_i(DLE),
    .par_en_i(par_en), .par_odd_i(par_odd),
    .ctrl_char_i(ctrl_chars), .ctrl_en_i(ctrl_en),
    .in_vld_i(in_vld), .in_data_i(in_data), .in_par_i(in_par),
    .cnt_clr_i(cnt_clr),
    .out_vld_o(out_vld), .out_data_o(out_data), .out_par_err_o(out_err),
    .out_ctrl_hit_o(out_hit), .out_ctrl_idx_o(out_idx),
    .par_err_cnt_o(cnt)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, bit e, string t);
    q_d.push_back(d); q_e.push_back(e); q_t.push_back(t);
    if (e) cnt_exp = (cnt_exp == CMAX) ? CMAX : cnt_exp + 1'b1;
  endtask

  task automatic model_in(logic [7:0] d, bit e);
    if (!transp) begin
      if (d != SYNC) push(d, e, "R1");
    end else if (!m_esc) begin
      if (d == DLE) begin m_esc = 1; m_esc_err = e; end
      else push(d, e, "R2");
    end else begin
      m_esc = 0;
      if (d == DLE) push(DLE, m_esc_err | e, "R4");
      else if (d != SYNC) begin push(DLE, m_esc_err, "R3"); push(d, e, "R3"); end
    end
  endtask

  task automatic sample();
    if (out_vld) begin
      if (q_d.size() == 0) begin
        chk(0, "R9", "unexpected strobe", out_data, 0);
      end else begin
        logic [7:0] d = q_d.pop_front();
        bit e = q_e.pop_front();
        string t = q_t.pop_front();
        bit hit = 0;
        int idx = 0;
        for (int i = NC - 1; i >= 0; i--)
          if (ctrl_en[i] && creg[i] == d) begin hit = 1; idx = i; end
        chk(out_data == d, t, "data", out_data, d);
        chk(out_err == (e & par_en), "R5", "parity flag", out_err, e);
        chk(out_hit == hit, "R6", "ctrl hit", out_hit, hit);
        if (hit) chk(out_idx == idx, "R6", "ctrl idx", out_idx, idx);
      end
    end else begin
      chk(!out_hit && !out_err, "R6", "flags without strobe", {out_hit, out_err}, 0);
    end
  endtask

  // one character, two-cycle slot; bad flips the parity bit
  task automatic send(logic [7:0] d, bit bad);
    @(negedge clk);
    in_vld = 1; in_data = d;
    in_par = (^d) ^ par_odd ^ bad;
    model_in(d, par_en & bad);
    @(negedge clk);
    sample();
    in_vld = 0;
    @(negedge clk);
    sample();
    chk(q_d.size() == 0, "R3", "pending expected outputs", q_d.size(), 0);
  endtask

  task automatic check_cnt(string tag);
    repeat (2) @(negedge clk);
    chk(cnt == cnt_exp, tag, "error count", cnt, cnt_exp);
  endtask

  task automatic do_clear();
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    cnt_exp = '0;
    chk(cnt == 0, "R8", "count after clear", cnt, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && out_hit == 0, "R10", "outputs in reset", {out_vld, out_hit}, 0);
    chk(cnt == 0, "R10", "count in reset", cnt, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_vld == 0, "R10", "idle after reset", out_vld, 0);

    // R1/R5/R6: normal mode, every byte, good parity
    for (int d = 0; d < 256; d++) send(8'(d), 0);
    check_cnt("R7");
    // R7: every byte with bad parity; 255 kept errors reach all ones
    for (int d = 0; d < 256; d++) send(8'(d), 1);
    check_cnt("R7");
    for (int d = 0; d < 8; d++) send(8'(d + 100), 1);
    check_cnt("R7");
    chk(cnt == CMAX, "R7", "saturated", cnt, CMAX);
    do_clear();

    // R8: clear on the same edge as a due increment
    @(negedge clk);
    in_vld = 1; in_data = 8'h55; in_par = (^in_data) ^ par_odd ^ 1'b1;
    model_in(8'h55, 1);
    @(negedge clk);
    sample();
    in_vld = 0; cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0; cnt_exp = '0;
    chk(cnt == 0, "R8", "clear beats increment", cnt, 0);

    // R9: dropped sync with bad parity leaves count alone
    send(SYNC, 1);
    check_cnt("R9");

    // transparent mode
    transp = 1;
    repeat (2) @(negedge clk);
    send(SYNC, 0);                 // R2 lone sync kept
    for (int d = 0; d < 256; d++) begin
      send(DLE, 0);
      send(8'(d), 0);
    end
    send(DLE, 1); send(SYNC, 1);   // R9 dropped pair, both bad
    check_cnt("R9");
    send(DLE, 1); send(DLE, 0);    // R4 error OR
    send(DLE, 0); send(DLE, 1);
    send(DLE, 0); send(DLE, 0); send(DLE, 0); send(SYNC, 0); // R4 escape cleared
    send(DLE, 1); send(8'h41, 0);  // R3 escape error only on escape
    check_cnt("R7");
    transp = 0;
    repeat (2) @(negedge clk);

    // R5: even parity and disabled parity, all parity-bit choices
    par_odd = 0;
    for (int d = 0; d < 64; d++) send(8'(d * 4 + 1), d[0]);
    par_en = 0;
    for (int d = 0; d < 64; d++) send(8'(d * 4 + 2), d[0]);
    check_cnt("R5");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule